// File: doc/BRIEF.md
# Cascadable Quad 8-Bit Timer Unit

This block holds four 8-bit down-counting timers, each with its own reload register. A timer counts on one of several clock enables: one of four taps of a free-running prescaler, rising edges of its own external event input, or, for the upper timer of a pair, the borrow of the lower timer. When a timer passes through zero it reloads. At that point it emits a one-cycle underflow pulse, sets its interrupt flag and flips its toggle output, so the toggle output runs at half the underflow rate.

Timers 0/1 and 2/3 can be joined into a single 16-bit divider. The lower timer borrows into the upper one, and the pair divides by the full 16-bit reload value plus one. In that mode the lower timer raises no interrupt and its toggle output stays still. The underflow pulses go to neighbouring blocks as baud clock enables. The last timer's pulse is also brought out as the A/D conversion start trigger. Software reaches the unit through a write strobe with address and data, plus a combinational read-back bus.

Top module: `tmr_quad`

Register map: `bus_addr[3:2]` selects the timer and `bus_addr[1:0]` selects the register.
- 0 is the reload value (read/write).
- 1 is control (read/write).
- 2 is the live counter (read-only).
- 3 reads as 0.

Control register fields:
- Bit 0 is the enable.
- Bits 2:1 are the source: 0 is the prescaler, 1 is the external event, 2 is cascade, 3 is off.
- Bits 4:3 pick the prescaler tap: 0 is /4, 1 is /64, 2 is /256, 3 is /512.
- Bit 7 reads the interrupt flag. Writing 1 to bit 7 clears the flag.

## Requirements
- R1: After reset all interrupt flags, toggle outputs, reload values and control fields read 0.
- R2: With source 0 and reload value R, an enabled timer underflows every (R+1)·D system clocks, where D is 4, 64, 256 or 512 for tap code 0, 1, 2 or 3.
- R3: With source 1, the timer counts each rising edge of its external event input after a two-flop synchronizer. With edges every P clocks it underflows every (R+1)·P clocks.
- R4: Source 2 on timer 1 or 3 forms a 16-bit pair with the timer below. The pair underflows once every (Rhi·256+Rlo+1) lower-timer clock enables. The lower timer's interrupt flag is not set and its toggle output does not move in this mode.
- R5: An interrupt flag is set on its timer's underflow and is cleared by a control write with bit 7 set; a same-cycle underflow wins over the clear.
- R6: Each toggle output flips on the clock after its timer's underflow pulse.
- R7: A disabled timer's counter reads its reload value and its toggle output holds its level.
- R8: A reload write to a running timer leaves the current period unchanged and sets the length of the following periods.
- R9: Source 3, or source 2 on timer 0 or 2, gives no clock enable: the counter holds its reload value and no interrupt is raised.
- R10: Underflow pulses are one clock wide, and `adc_trig` equals timer 3's underflow pulse.
- R11: The counter register (offset 2) returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address {timer, offset} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ev_in | input | 4 | External event inputs, one per timer |
| udf_pulse | output | 4 | One-cycle underflow pulses |
| irq | output | 4 | Interrupt request flags |
| tog_out | output | 4 | Toggle outputs |
| adc_trig | output | 1 | A/D conversion start trigger |

## Verification
The bench builds the unit with its default parameters: four timers, 8-bit counters and prescaler tap exponents 2, 6, 8 and 9. With these settings every tap, including the /512 one, produces an underflow within a thousand clocks when the reload value is small. A 16-bit pair with a nonzero upper byte also completes a full period in about a thousand clocks, so the whole cascade count, borrow wrap included, can be measured exactly. Periods are compared as intervals between successive underflow pulses, which removes any dependence on prescaler phase or synchronizer latency.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the quad timer unit.
// Assumes an 8-bit register bus and a 2-bit offset field in the address.
package tmr_pkg;
    localparam logic [1:0] SRC_PRE  = 2'd0;
    localparam logic [1:0] SRC_EXT  = 2'd1;
    localparam logic [1:0] SRC_CASC = 2'd2;
    localparam logic [1:0] SRC_OFF  = 2'd3;

    localparam logic [1:0] OFS_RLD  = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_CNT  = 2'd2;

    localparam int IRQ_BIT = 7;

    typedef struct packed {
        logic [1:0] tap;
        logic [1:0] src;
        logic       en;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running prescaler with four power-of-two taps.
// Each tap pulses for one cycle every 2**LOG_x clocks; LOG_D must be the largest.
module tmr_prescaler #(
    parameter int LOG_A = 2,
    parameter int LOG_B = 6,
    parameter int LOG_C = 8,
    parameter int LOG_D = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [3:0] tap_tick
);
    localparam int TAPS [4] = '{LOG_A, LOG_B, LOG_C, LOG_D};

    logic [LOG_D-1:0] div_q;

    // Free-running divide counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    for (genvar i = 0; i < 4; i++) begin : g_tap
        assign tap_tick[i] = &div_q[TAPS[i]-1:0];
    end
endmodule

// File: rtl/tmr_evsync.sv
// Brings external event inputs into the clock domain and detects rising edges.
// Assumes each input changes no faster than a quarter of the system clock rate.
module tmr_evsync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_raw,
    output logic [N-1:0] ev_rise
);
    for (genvar i = 0; i < N; i++) begin : g_sync
        logic s1_q, s2_q, s3_q;

        // Two-flop synchronizer plus one delay flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= ev_raw[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign ev_rise[i] = s2_q & ~s3_q;
    end
endmodule

// File: rtl/tmr_pair.sv
// Two 8-bit reload down-counters that can act as one 16-bit divider.
// When casc is set the upper counter steps on the lower borrow, the lower
// counter wraps to all ones except at a full 16-bit zero, and the lower
// toggle output holds. A disabled counter is held at its reload value.
module tmr_pair #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       en,
    input  logic             tick_lo,
    input  logic             tick_hi,
    input  logic             casc,
    input  logic [CNT_W-1:0] rld_lo,
    input  logic [CNT_W-1:0] rld_hi,
    output logic [CNT_W-1:0] cnt_lo,
    output logic [CNT_W-1:0] cnt_hi,
    output logic [1:0]       udf,
    output logic [1:0]       tog
);
    logic step_hi;

    assign udf[0]  = en[0] & tick_lo & (cnt_lo == '0);
    assign step_hi = casc ? udf[0] : tick_hi;
    assign udf[1]  = en[1] & step_hi & (cnt_hi == '0);

    // Lower counter: reload, wrap on borrow in cascade, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_lo <= '0;
        else if (!en[0])          cnt_lo <= rld_lo;
        else if (tick_lo) begin
            if (cnt_lo != '0)     cnt_lo <= cnt_lo - 1'b1;
            else if (casc && cnt_hi != '0) cnt_lo <= '1;
            else                  cnt_lo <= rld_lo;
        end
    end

    // Upper counter: reload on disable or underflow, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_hi <= '0;
        else if (!en[1])          cnt_hi <= rld_hi;
        else if (step_hi) begin
            if (cnt_hi != '0)     cnt_hi <= cnt_hi - 1'b1;
            else                  cnt_hi <= rld_hi;
        end
    end

    // Toggle outputs flip on underflow; the lower one is frozen in cascade.
    always_ff @(posedge clk) begin
        if (!rst_n) tog <= '0;
        else begin
            if (udf[0] && !casc) tog[0] <= ~tog[0];
            if (udf[1])          tog[1] <= ~tog[1];
        end
    end
endmodule

// File: rtl/tmr_quad.sv
// Quad 8-bit timer unit with register port, clock selection and pairing.
// Assumes NUM_TMR is even and CNT_W is 8 (the bus carries the irq flag in bit 7).
module tmr_quad
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 8,
    parameter int LOG_A   = 2,
    parameter int LOG_B   = 6,
    parameter int LOG_C   = 8,
    parameter int LOG_D   = 9,
    localparam int IDX_W  = $clog2(NUM_TMR),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [NUM_TMR-1:0] ev_in,
    output logic [NUM_TMR-1:0] udf_pulse,
    output logic [NUM_TMR-1:0] irq,
    output logic [NUM_TMR-1:0] tog_out,
    output logic               adc_trig
);
    localparam int NUM_PAIR = NUM_TMR / 2;
    localparam int CTRL_W   = $bits(tmr_ctrl_t);

    logic [NUM_TMR-1:0][CNT_W-1:0] rld_q;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_w;
    tmr_ctrl_t [NUM_TMR-1:0]       ctrl_q;
    logic [NUM_TMR-1:0]            irq_q;
    logic [NUM_TMR-1:0]            tick_w;
    logic [NUM_TMR-1:0]            casc_w;
    logic [NUM_TMR-1:0]            lo_quiet;
    logic [NUM_TMR-1:0]            ev_rise;
    logic [3:0]                    tap_tick;
    logic [IDX_W-1:0]              sel_idx;
    logic [1:0]                    sel_ofs;

    assign sel_idx = bus_addr[ADDR_W-1:2];
    assign sel_ofs = bus_addr[1:0];

    tmr_prescaler #(
        .LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C), .LOG_D(LOG_D)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .tap_tick(tap_tick)
    );

    tmr_evsync #(.N(NUM_TMR)) u_sync (
        .clk(clk), .rst_n(rst_n), .ev_raw(ev_in), .ev_rise(ev_rise)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_sel
        // Per-timer clock enable selection.
        always_comb begin
            case (ctrl_q[t].src)
                SRC_PRE: tick_w[t] = tap_tick[ctrl_q[t].tap];
                SRC_EXT: tick_w[t] = ev_rise[t];
                default: tick_w[t] = 1'b0;
            endcase
        end
        if (t % 2 == 1) begin : g_odd
            assign casc_w[t]   = (ctrl_q[t].src == SRC_CASC);
            assign lo_quiet[t] = 1'b0;
        end else begin : g_even
            assign casc_w[t]   = 1'b0;
            assign lo_quiet[t] = (ctrl_q[t+1].src == SRC_CASC);
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        tmr_pair #(.CNT_W(CNT_W)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     ({ctrl_q[2*p+1].en, ctrl_q[2*p].en}),
            .tick_lo(tick_w[2*p]),
            .tick_hi(tick_w[2*p+1]),
            .casc   (casc_w[2*p+1]),
            .rld_lo (rld_q[2*p]),
            .rld_hi (rld_q[2*p+1]),
            .cnt_lo (cnt_w[2*p]),
            .cnt_hi (cnt_w[2*p+1]),
            .udf    (udf_pulse[2*p+1:2*p]),
            .tog    (tog_out[2*p+1:2*p])
        );
    end

    // Register writes and interrupt flag set/clear (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q  <= '0;
            ctrl_q <= '0;
            irq_q  <= '0;
        end else begin
            for (int t = 0; t < NUM_TMR; t++) begin
                if (bus_we && sel_idx == IDX_W'(t)) begin
                    if (sel_ofs == OFS_RLD) rld_q[t] <= bus_wdata;
                    if (sel_ofs == OFS_CTRL) begin
                        ctrl_q[t] <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                        if (bus_wdata[IRQ_BIT]) irq_q[t] <= 1'b0;
                    end
                end
                if (udf_pulse[t] && !lo_quiet[t]) irq_q[t] <= 1'b1;
            end
        end
    end

    // Combinational read-back.
    always_comb begin
        bus_rdata = '0;
        case (sel_ofs)
            OFS_RLD:  bus_rdata = rld_q[sel_idx];
            OFS_CTRL: begin
                bus_rdata[CTRL_W-1:0] = ctrl_q[sel_idx];
                bus_rdata[IRQ_BIT]    = irq_q[sel_idx];
            end
            OFS_CNT:  bus_rdata = cnt_w[sel_idx];
            default:  bus_rdata = '0;
        endcase
    end

    assign irq      = irq_q;
    assign adc_trig = udf_pulse[NUM_TMR-1];
endmodule

// File: rtl/tmr_quad_chk.sv
// Assertion checker for tmr_quad, attached by bind. Watches ports and the
// cascade suppression vector that the selection logic drives.
module tmr_quad_chk #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [7:0]         bus_wdata,
    input logic [NUM_TMR-1:0] udf_pulse,
    input logic [NUM_TMR-1:0] irq,
    input logic [NUM_TMR-1:0] tog_out,
    input logic [NUM_TMR-1:0] lo_quiet,
    input logic               adc_trig
);
    for (genvar k = 0; k < NUM_TMR; k++) begin : g_k
        AST_UDF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            udf_pulse[k] |=> !udf_pulse[k]); // R10

        AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (udf_pulse[k] && !lo_quiet[k]) |=> irq[k]); // R5

        AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(4*k+1) && bus_wdata[7] && !udf_pulse[k])
            |=> !irq[k]); // R5

        AST_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_quiet[k] && !irq[k]) |=> !irq[k]); // R4

        AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            (udf_pulse[k] && !lo_quiet[k]) |=> (tog_out[k] != $past(tog_out[k]))); // R6

        AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!udf_pulse[k] || lo_quiet[k]) |=> $stable(tog_out[k])); // R7
    end

    AST_ADC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig); // R10
endmodule

bind tmr_quad tmr_quad_chk #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .udf_pulse(udf_pulse), .irq(irq),
    .tog_out(tog_out), .lo_quiet(lo_quiet), .adc_trig(adc_trig)
);

// File: tb/tmr_quad_test.sv
// Scoreboard bench: drivers queue expected underflow intervals, a monitor
// measures intervals between pulses of the watched timer and compares.
module tmr_quad_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] ev_in = '0;
    logic [3:0] udf_pulse, irq, tog_out;
    logic       adc_trig;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int mon_idx = 0;
    bit armed = 0;
    int last_t = 0;
    bit ev_run = 0;
    string mon_tag = "";
    int exp_q[$];

    tmr_quad uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_in(ev_in),
        .udf_pulse(udf_pulse), .irq(irq), .tog_out(tog_out), .adc_trig(adc_trig)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor: interval between successive underflows of the watched timer.
    always @(negedge clk) begin
        if (rst_n && udf_pulse[mon_idx]) begin
            if (armed && exp_q.size() > 0)
                check(mon_tag, cyc - last_t, exp_q.pop_front());
            armed  <= 1'b1;
            last_t <= cyc;
        end
        if (rst_n && udf_pulse[3]) check("R10 adc_trig", int'(adc_trig), 1);
    end

    // External event source: rising edge every 8 clocks.
    always @(negedge clk) if (ev_run) ev_in[3] <= ((cyc / 4) % 2) != 0;

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic watch(int idx, string tag);
        @(negedge clk);
        mon_idx = idx; mon_tag = tag; armed = 0;
    endtask

    task automatic push(int period, int n);
        for (int i = 0; i < n; i++) exp_q.push_back(period);
    endtask

    task automatic drain(string tag);
        int w = 0;
        while (exp_q.size() > 0 && w < 20000) begin
            @(negedge clk); w++;
        end
        if (exp_q.size() > 0) begin
            check({tag, " timeout"}, exp_q.size(), 0);
            exp_q.delete();
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int v;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", int'(irq), 0);
        check("R1 tog", int'(tog_out), 0);
        rd(4'h0, v); check("R1 reload0", v, 0);
        rd(4'hD, v); check("R1 ctrl3", v, 0);

        // R2: /4 tap, reload 5 -> 24 clocks.
        wr(4'h0, 8'd5);
        watch(0, "R2 div4");
        wr(4'h1, 8'h01);
        push(24, 2); drain("R2 div4");
        check("R5 irq set", int'(irq[0]), 1);

        // R6: toggle flips the clock after a pulse.
        while (!udf_pulse[0]) @(negedge clk);
        t0 = int'(tog_out[0]);
        @(negedge clk);
        check("R6 toggle", int'(tog_out[0]), 1 - t0);

        // R8: reload write mid-period takes effect after next underflow.
        idle(3);
        wr(4'h0, 8'd9);
        mon_tag = "R8 reload";
        push(24, 1); push(40, 1); drain("R8 reload");

        // R11: live counter changes while running.
        rd(4'h2, v); t0 = v; idle(8); rd(4'h2, v);
        check("R11 counter moves", int'(v != t0), 1);

        // R5 clear and R7 disable.
        idle(5);
        wr(4'h1, 8'h80);
        check("R5 irq clear", int'(irq[0]), 0);
        t0 = int'(tog_out[0]);
        idle(200);
        check("R7 tog hold", int'(tog_out[0]), t0);
        rd(4'h2, v); check("R7 counter=reload", v, 9);

        // R2: /64 tap on timer 1, /512 tap on timer 2.
        wr(4'h4, 8'd2);
        watch(1, "R2 div64");
        wr(4'h5, 8'h09);
        push(192, 2); drain("R2 div64");
        wr(4'h5, 8'h80);
        wr(4'h8, 8'd1);
        watch(2, "R2 div512");
        wr(4'h9, 8'h19);
        push(1024, 1); drain("R2 div512");
        wr(4'h9, 8'h80);

        // R3: external events every 8 clocks, reload 4 -> 40 clocks.
        ev_run = 1;
        wr(4'hC, 8'd4);
        watch(3, "R3 ext");
        wr(4'hD, 8'h03);
        push(40, 2); drain("R3 ext");
        wr(4'hD, 8'h80);
        ev_run = 0;

        // R4: cascade pair 0/1, lower /4, reload {1,3} -> 260*4 clocks.
        wr(4'h0, 8'd3);
        wr(4'h4, 8'd1);
        wr(4'h5, 8'h85);
        wr(4'h1, 8'h81);
        t0 = int'(tog_out[0]);
        watch(1, "R4 cascade");
        push(1040, 1); drain("R4 cascade");
        check("R4 lower irq quiet", int'(irq[0]), 0);
        check("R4 upper irq", int'(irq[1]), 1);
        check("R4 lower tog hold", int'(tog_out[0]), t0);
        wr(4'h1, 8'h80);
        wr(4'h5, 8'h80);

        // R9: no-clock sources hold the counter.
        wr(4'h8, 8'd7);
        wr(4'h9, 8'h85);
        wr(4'hC, 8'd6);
        wr(4'hD, 8'h87);
        idle(600);
        rd(4'hA, v); check("R9 even cascade holds", v, 7);
        rd(4'hE, v); check("R9 off holds", v, 6);
        check("R9 no irq", int'(irq[3:2]), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule